// File: doc/BRIEF.md
# FIFO trigger-level interrupt controller

This block holds the transmit and receive queues of one serial channel and turns their fill state into interrupt requests. The CPU side writes characters into the transmit queue and reads them from the receive queue. The serial side drains the transmit queue and fills the receive queue. Each queue is 64 entries deep and has its own programmable trigger threshold. A receive idle timer raises a separate request when characters wait below the threshold, so that they still reach the CPU. The shift engines, the baud generator and the register decode sit outside the block.

Configuration arrives as writes of the FIFO control byte, using the encodings listed below. A separate level input enables the extended features, and the programmed transmit threshold applies only while that input is high. Every data path uses a valid/ready handshake. A producer is expected to hold `*_in_valid` low while `*_in_ready` is low. A character offered anyway is discarded and sets that queue's sticky overrun flag; the producer is never stalled. A consumer may assert `*_out_ready` at any time. When the queue is empty the request has no effect, and `*_out_data` keeps showing the last character removed.

Top module: `fifo_irq_ctrl`

## Requirements
- R1: After reset both levels are 0, queueing is disabled, both overrun flags and both receive requests are low, `irq_tx_ready` is high, and both `*_in_ready` are high.
- R2: Control bit 0 enables the 64-entry queues. While it is 0, each direction holds a single character: `*_in_ready` drops once one character is stored.
- R3: Control bits 7:6 select the receive threshold: 0→8, 1→16, 2→56, 3→60 characters. `irq_rx_data` is high exactly while `rx_level` is at or above the threshold. With queueing disabled the threshold is 1.
- R4: Control bits 5:4 select the transmit threshold: 0→8, 1→16, 2→32, 3→56 free slots. `irq_tx_ready` is high exactly while the free space (capacity minus `tx_level`) is at or above the threshold. With queueing disabled the threshold is 1.
- R5: While `enh_en` is low, the transmit threshold is 8 whatever was programmed. The stored selection takes effect as soon as `enh_en` rises, with no new write.
- R6: A control write with bit 1 set empties the receive queue, and with bit 2 set empties the transmit queue. Neither bit is stored. A write that changes bit 0 empties both queues. Emptying clears that queue's overrun flag and takes priority over a push in the same cycle.
- R7: Characters leave each queue in arrival order. `*_out_data` shows the oldest character while `*_out_valid` is high.
- R8: A character offered while `*_in_ready` is low is dropped, the level is unchanged, and the queue's overrun flag rises and stays high until that queue is emptied by R6 or reset.
- R9: A pop from an empty queue leaves the level at 0 and `*_out_data` at the last character removed.
- R10: `irq_rx_timeout` rises after 4 `char_tick` pulses with no receive push or pop while the receive queue is not empty. Any such push or pop restarts the count, and the request is never high while the queue is empty.
- R11: A push and a pop on the same queue in the same cycle, when neither full nor empty, leave the level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fcr_we | input | 1 | Control byte write strobe |
| fcr_wdata | input | 8 | Control byte value |
| enh_en | input | 1 | Extended features enable (gates transmit threshold) |
| tx_in_valid | input | 1 | CPU offers a transmit character |
| tx_in_ready | output | 1 | Transmit queue has room |
| tx_in_data | input | 8 | Transmit character in |
| tx_out_valid | output | 1 | Transmit queue not empty |
| tx_out_ready | input | 1 | Shifter takes a transmit character |
| tx_out_data | output | 8 | Oldest transmit character |
| rx_in_valid | input | 1 | Shifter offers a received character |
| rx_in_ready | output | 1 | Receive queue has room |
| rx_in_data | input | 8 | Received character in |
| rx_out_valid | output | 1 | Receive queue not empty |
| rx_out_ready | input | 1 | CPU takes a received character |
| rx_out_data | output | 8 | Oldest received character |
| char_tick | input | 1 | One pulse per character time |
| irq_rx_data | output | 1 | Receive level at or above threshold |
| irq_tx_ready | output | 1 | Transmit free space at or above threshold |
| irq_rx_timeout | output | 1 | Receive idle time-out request |
| rx_level | output | 7 | Receive fill level |
| tx_level | output | 7 | Transmit fill level |
| rx_overrun | output | 1 | Sticky receive overrun |
| tx_overrun | output | 1 | Sticky transmit overrun |

## Verification
Two pairs of functions can land in the same cycle. The first is a receive push and a receive pop: the bench raises `rx_in_valid` and `rx_out_ready` on the same edge while the queue holds three characters, then expects the level to stay at 3 and the output order to remain intact. The second is a receive flush and a receive push: the bench writes the flush bit in the cycle a character is offered, then expects the queue to be empty and the overrun flag clear, which confirms that the flush wins. The threshold requests are swept over every fill level from 0 to 64 for every selection, and the expected value is computed arithmetically.

// File: rtl/fifo_irq_pkg.sv
package fifo_irq_pkg;

  localparam int unsigned QDEPTH       = 64;
  localparam int unsigned TX_TRIG_BOOT = 8;
  localparam int unsigned IDLE_TICKS   = 4;

  // receive threshold in stored characters
  function automatic int unsigned rx_trig_of(input logic [1:0] sel);
    case (sel)
      2'd0:    return 8;
      2'd1:    return 16;
      2'd2:    return 56;
      default: return 60;
    endcase
  endfunction

  // transmit threshold in free slots
  function automatic int unsigned tx_trig_of(input logic [1:0] sel);
    case (sel)
      2'd0:    return 8;
      2'd1:    return 16;
      2'd2:    return 32;
      default: return 56;
    endcase
  endfunction

endpackage

// File: rtl/irq_queue.sv
module irq_queue #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          single,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty,
  output logic          overrun
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [LW-1:0] cnt_q;
  logic [DW-1:0] last_q;
  logic          ovr_q;
  logic          push_ok, pop_ok;

  assign empty   = (cnt_q == '0);
  assign full    = single ? !empty : (cnt_q == LW'(DEPTH));
  assign push_ok = push && !full && !flush;
  assign pop_ok  = pop && !empty && !flush;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_q] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q   <= '0;
      rd_q   <= '0;
      cnt_q  <= '0;
      ovr_q  <= 1'b0;
      last_q <= '0;
    end else if (flush) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      if (push_ok) wr_q <= wr_q + 1'b1;
      if (pop_ok) begin
        rd_q   <= rd_q + 1'b1;
        last_q <= mem[rd_q];
      end
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
      if (push && full) ovr_q <= 1'b1;
    end
  end

  assign rdata   = empty ? last_q : mem[rd_q];
  assign level   = cnt_q;
  assign overrun = ovr_q;

endmodule

// File: rtl/irq_trig_sel.sv
module irq_trig_sel
  import fifo_irq_pkg::*;
#(
  parameter int unsigned LW = 7
) (
  input  logic          fifo_en,
  input  logic          enh,
  input  logic [1:0]    rx_sel,
  input  logic [1:0]    tx_sel,
  output logic [LW-1:0] rx_trig,
  output logic [LW-1:0] tx_trig
);

  always_comb begin
    if (!fifo_en) begin
      rx_trig = LW'(1);
      tx_trig = LW'(1);
    end else begin
      rx_trig = LW'(rx_trig_of(rx_sel));
      tx_trig = enh ? LW'(tx_trig_of(tx_sel)) : LW'(TX_TRIG_BOOT);
    end
  end

endmodule

// File: rtl/rx_idle_timer.sv
module rx_idle_timer #(
  parameter int unsigned TICKS = 4,
  localparam int unsigned CW   = $clog2(TICKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic empty,
  input  logic tick,
  output logic fire
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                          cnt_q <= '0;
    else if (restart || empty)           cnt_q <= '0;
    else if (tick && cnt_q != CW'(TICKS)) cnt_q <= cnt_q + 1'b1;
  end

  assign fire = (cnt_q == CW'(TICKS)) && !empty;

endmodule

// File: rtl/fifo_irq_ctrl.sv
module fifo_irq_ctrl
  import fifo_irq_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = QDEPTH,
  parameter int unsigned TICKS = IDLE_TICKS,
  localparam int unsigned LW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fcr_we,
  input  logic [7:0]    fcr_wdata,
  input  logic          enh_en,
  input  logic          tx_in_valid,
  output logic          tx_in_ready,
  input  logic [DW-1:0] tx_in_data,
  output logic          tx_out_valid,
  input  logic          tx_out_ready,
  output logic [DW-1:0] tx_out_data,
  input  logic          rx_in_valid,
  output logic          rx_in_ready,
  input  logic [DW-1:0] rx_in_data,
  output logic          rx_out_valid,
  input  logic          rx_out_ready,
  output logic [DW-1:0] rx_out_data,
  input  logic          char_tick,
  output logic          irq_rx_data,
  output logic          irq_tx_ready,
  output logic          irq_rx_timeout,
  output logic [LW-1:0] rx_level,
  output logic [LW-1:0] tx_level,
  output logic          rx_overrun,
  output logic          tx_overrun
);

  logic       fifo_en_q;
  logic [1:0] rx_sel_q, tx_sel_q;
  logic       unused_fcr_bit3;
  logic       mode_flip, rx_flush, tx_flush;
  logic       rx_full, rx_empty, tx_full, tx_empty;
  logic       rx_activity;
  logic [LW-1:0] rx_trig, tx_trig, tx_cap, tx_free;

  assign unused_fcr_bit3 = fcr_wdata[3];

  // control byte capture; flush bits are strobes and are not kept
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fifo_en_q <= 1'b0;
      rx_sel_q  <= 2'd0;
      tx_sel_q  <= 2'd0;
    end else if (fcr_we) begin
      fifo_en_q <= fcr_wdata[0];
      rx_sel_q  <= fcr_wdata[7:6];
      tx_sel_q  <= fcr_wdata[5:4];
    end
  end

  assign mode_flip = fcr_we && (fcr_wdata[0] != fifo_en_q);
  assign rx_flush  = fcr_we && (fcr_wdata[1] || mode_flip);
  assign tx_flush  = fcr_we && (fcr_wdata[2] || mode_flip);

  irq_queue #(.DW(DW), .DEPTH(DEPTH)) i_rxq (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush), .single(!fifo_en_q),
    .push(rx_in_valid), .pop(rx_out_ready), .wdata(rx_in_data),
    .rdata(rx_out_data), .level(rx_level), .full(rx_full),
    .empty(rx_empty), .overrun(rx_overrun)
  );

  irq_queue #(.DW(DW), .DEPTH(DEPTH)) i_txq (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush), .single(!fifo_en_q),
    .push(tx_in_valid), .pop(tx_out_ready), .wdata(tx_in_data),
    .rdata(tx_out_data), .level(tx_level), .full(tx_full),
    .empty(tx_empty), .overrun(tx_overrun)
  );

  irq_trig_sel #(.LW(LW)) i_trig (
    .fifo_en(fifo_en_q), .enh(enh_en), .rx_sel(rx_sel_q), .tx_sel(tx_sel_q),
    .rx_trig(rx_trig), .tx_trig(tx_trig)
  );

  assign rx_activity = rx_in_valid || (rx_out_ready && !rx_empty);

  rx_idle_timer #(.TICKS(TICKS)) i_idle (
    .clk(clk), .rst_n(rst_n), .restart(rx_activity || rx_flush),
    .empty(rx_empty), .tick(char_tick), .fire(irq_rx_timeout)
  );

  assign tx_cap  = fifo_en_q ? LW'(DEPTH) : LW'(1);
  assign tx_free = tx_cap - tx_level;

  assign rx_in_ready  = !rx_full;
  assign tx_in_ready  = !tx_full;
  assign rx_out_valid = !rx_empty;
  assign tx_out_valid = !tx_empty;
  assign irq_rx_data  = (rx_level >= rx_trig);
  assign irq_tx_ready = (tx_free >= tx_trig);

endmodule

// File: rtl/fifo_irq_ctrl_chk.sv
module fifo_irq_ctrl_chk #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned LW    = 7,
  parameter int unsigned DW    = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fcr_we,
  input logic [7:0]    fcr_wdata,
  input logic          enh_en,
  input logic          fifo_en_q,
  input logic          rx_in_valid,
  input logic          rx_in_ready,
  input logic          rx_out_valid,
  input logic          rx_out_ready,
  input logic [DW-1:0] rx_out_data,
  input logic          irq_tx_ready,
  input logic          irq_rx_timeout,
  input logic [LW-1:0] rx_level,
  input logic [LW-1:0] tx_level,
  input logic          rx_overrun
);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level <= LW'(DEPTH)) && (tx_level <= LW'(DEPTH))); // R2

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level == LW'(DEPTH) && rx_in_valid && !rx_out_ready && !fcr_we)
    |=> (rx_level == LW'(DEPTH) && rx_overrun)); // R8

  AST_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level == '0 && rx_out_ready && !rx_in_valid && !fcr_we)
    |=> (rx_level == '0 && $stable(rx_out_data))); // R9

  AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level == '0) |-> !irq_rx_timeout); // R10

  AST_TX_BOOT_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en_q && !enh_en && tx_level <= LW'(DEPTH - 8)) |-> irq_tx_ready); // R5

  AST_PUSH_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!fcr_we && rx_in_valid && rx_in_ready && rx_out_ready && rx_out_valid)
    |=> $stable(rx_level)); // R11

  AST_RX_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (fcr_we && fcr_wdata[1]) |=> (rx_level == '0 && !rx_overrun)); // R6

endmodule

bind fifo_irq_ctrl fifo_irq_ctrl_chk #(.DEPTH(DEPTH), .LW(LW), .DW(DW)) i_chk (
  .clk(clk), .rst_n(rst_n), .fcr_we(fcr_we), .fcr_wdata(fcr_wdata),
  .enh_en(enh_en), .fifo_en_q(fifo_en_q), .rx_in_valid(rx_in_valid),
  .rx_in_ready(rx_in_ready), .rx_out_valid(rx_out_valid),
  .rx_out_ready(rx_out_ready), .rx_out_data(rx_out_data),
  .irq_tx_ready(irq_tx_ready), .irq_rx_timeout(irq_rx_timeout),
  .rx_level(rx_level), .tx_level(tx_level), .rx_overrun(rx_overrun)
);

// File: tb/test_fifo_irq_ctrl.sv
module test_fifo_irq_ctrl;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       fcr_we = 1'b0;
  logic [7:0] fcr_wdata = '0;
  logic       enh_en = 1'b0;
  logic       tx_in_valid = 1'b0, tx_out_ready = 1'b0;
  logic       rx_in_valid = 1'b0, rx_out_ready = 1'b0;
  logic [7:0] tx_in_data = '0, rx_in_data = '0;
  logic       char_tick = 1'b0;
  logic       tx_in_ready, tx_out_valid, rx_in_ready, rx_out_valid;
  logic [7:0] tx_out_data, rx_out_data;
  logic       irq_rx_data, irq_tx_ready, irq_rx_timeout, rx_overrun, tx_overrun;
  logic [6:0] rx_level, tx_level;

  fifo_irq_ctrl i_fifo_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .fcr_we(fcr_we), .fcr_wdata(fcr_wdata),
    .enh_en(enh_en), .tx_in_valid(tx_in_valid), .tx_in_ready(tx_in_ready),
    .tx_in_data(tx_in_data), .tx_out_valid(tx_out_valid),
    .tx_out_ready(tx_out_ready), .tx_out_data(tx_out_data),
    .rx_in_valid(rx_in_valid), .rx_in_ready(rx_in_ready),
    .rx_in_data(rx_in_data), .rx_out_valid(rx_out_valid),
    .rx_out_ready(rx_out_ready), .rx_out_data(rx_out_data),
    .char_tick(char_tick), .irq_rx_data(irq_rx_data),
    .irq_tx_ready(irq_tx_ready), .irq_rx_timeout(irq_rx_timeout),
    .rx_level(rx_level), .tx_level(tx_level),
    .rx_overrun(rx_overrun), .tx_overrun(tx_overrun)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  int rx_t[4] = '{8, 16, 56, 60};
  int tx_t[4] = '{8, 16, 32, 56};

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic fcr(input logic [7:0] v);
    @(negedge clk); fcr_we = 1'b1; fcr_wdata = v;
    @(negedge clk); fcr_we = 1'b0;
  endtask

  task automatic rx_push(input logic [7:0] d);
    @(negedge clk); rx_in_valid = 1'b1; rx_in_data = d;
    @(negedge clk); rx_in_valid = 1'b0;
  endtask

  task automatic tx_push(input logic [7:0] d);
    @(negedge clk); tx_in_valid = 1'b1; tx_in_data = d;
    @(negedge clk); tx_in_valid = 1'b0;
  endtask

  task automatic rx_pop(output logic [7:0] d);
    @(negedge clk); d = rx_out_data; rx_out_ready = 1'b1;
    @(negedge clk); rx_out_ready = 1'b0;
  endtask

  task automatic tx_pop(output logic [7:0] d);
    @(negedge clk); d = tx_out_data; tx_out_ready = 1'b1;
    @(negedge clk); tx_out_ready = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); char_tick = 1'b1;
    @(negedge clk); char_tick = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 rx_level", rx_level, 0);
    chk("R1 tx_level", tx_level, 0);
    chk("R1 irq_rx_data", irq_rx_data, 0);
    chk("R1 irq_tx_ready", irq_tx_ready, 1);
    chk("R1 irq_rx_timeout", irq_rx_timeout, 0);
    chk("R1 overruns", {rx_overrun, tx_overrun}, 0);
    chk("R1 in_ready", {rx_in_ready, tx_in_ready}, 3);

    // R2 single-character mode
    rx_push(8'hA5);
    chk("R2 rx_level single", rx_level, 1);
    chk("R2 rx_in_ready single", rx_in_ready, 0);
    chk("R3 irq_rx_data threshold 1", irq_rx_data, 1);
    rx_push(8'h5A);
    chk("R8 rx_overrun single", rx_overrun, 1);
    chk("R8 rx_level kept", rx_level, 1);
    rx_pop(d);
    chk("R7 rx data single", d, 8'hA5);
    rx_pop(d);
    chk("R9 empty pop data", rx_out_data, 8'hA5);
    chk("R9 empty pop level", rx_level, 0);
    tx_push(8'h11);
    chk("R4 irq_tx_ready single full", irq_tx_ready, 0);
    chk("R2 tx_in_ready single", tx_in_ready, 0);

    // R6 mode change empties both queues
    fcr(8'h01);
    chk("R6 mode flip tx_level", tx_level, 0);
    chk("R6 mode flip rx_overrun", rx_overrun, 0);

    // R3 receive threshold sweep
    for (int s = 0; s < 4; s++) begin
      fcr(8'((s << 6) | 8'h03));
      for (int n = 1; n <= 64; n++) begin
        rx_push(8'((n * 7 + s) & 255));
        chk("R3 rx_level", rx_level, n);
        chk("R3 irq_rx_data", irq_rx_data, int'(n >= rx_t[s]));
      end
      chk("R8 rx_in_ready full", rx_in_ready, 0);
      rx_push(8'hEE);
      chk("R8 rx_overrun", rx_overrun, 1);
      chk("R8 rx_level full", rx_level, 64);
      for (int n = 1; n <= 64; n++) begin
        rx_pop(d);
        chk("R7 rx order", d, (n * 7 + s) & 255);
        chk("R3 irq_rx_data drain", irq_rx_data, int'((64 - n) >= rx_t[s]));
      end
      rx_pop(d);
      chk("R9 rx empty pop", d, (64 * 7 + s) & 255);
      chk("R9 rx level", rx_level, 0);
    end

    // R5 boot threshold without extended enable
    fcr(8'h35);
    for (int n = 1; n <= 64; n++) begin
      tx_push(8'(n));
      chk("R5 irq_tx_ready boot 8", irq_tx_ready, int'((64 - n) >= 8));
    end
    tx_push(8'hFF);
    chk("R8 tx_overrun", tx_overrun, 1);
    fcr(8'h25);
    chk("R6 tx flush clears overrun", tx_overrun, 0);
    for (int n = 1; n <= 33; n++) tx_push(8'(n));
    chk("R5 free 31 with boot 8", irq_tx_ready, 1);
    @(negedge clk); enh_en = 1'b1;
    @(negedge clk);
    chk("R5 stored 32 takes effect", irq_tx_ready, 0);
    enh_en = 1'b0;
    @(negedge clk);
    chk("R5 back to boot 8", irq_tx_ready, 1);
    enh_en = 1'b1;

    // R4 transmit threshold sweep with extended enable
    for (int s = 0; s < 4; s++) begin
      fcr(8'((s << 4) | 8'h05));
      chk("R4 tx empty", irq_tx_ready, 1);
      for (int n = 1; n <= 64; n++) begin
        tx_push(8'((n * 3 + s) & 255));
        chk("R4 irq_tx_ready", irq_tx_ready, int'((64 - n) >= tx_t[s]));
      end
    end
    for (int n = 1; n <= 64; n++) begin
      tx_pop(d);
      chk("R7 tx order", d, (n * 3 + 3) & 255);
    end
    chk("R4 tx drained", irq_tx_ready, 1);

    // R10 idle time-out
    fcr(8'h07);
    rx_push(8'd1); rx_push(8'd2); rx_push(8'd3);
    for (int k = 1; k <= 3; k++) begin
      tick();
      chk("R10 before 4 ticks", irq_rx_timeout, 0);
    end
    tick();
    chk("R10 at 4 ticks", irq_rx_timeout, 1);
    tick();
    chk("R10 holds", irq_rx_timeout, 1);
    rx_pop(d);
    chk("R10 pop restarts", irq_rx_timeout, 0);
    for (int k = 1; k <= 3; k++) tick();
    rx_push(8'd4);
    for (int k = 1; k <= 3; k++) tick();
    chk("R10 push restarts", irq_rx_timeout, 0);
    tick();
    chk("R10 fires after restart", irq_rx_timeout, 1);
    for (int k = 1; k <= 3; k++) rx_pop(d);
    for (int k = 1; k <= 5; k++) tick();
    chk("R10 empty no request", irq_rx_timeout, 0);

    // R11 push and pop in one cycle
    rx_push(8'd21); rx_push(8'd22); rx_push(8'd23);
    @(negedge clk);
    d = rx_out_data;
    rx_in_valid = 1'b1; rx_in_data = 8'd24; rx_out_ready = 1'b1;
    @(negedge clk);
    rx_in_valid = 1'b0; rx_out_ready = 1'b0;
    chk("R11 level unchanged", rx_level, 3);
    chk("R11 popped oldest", d, 21);
    for (int k = 0; k < 3; k++) begin
      rx_pop(d);
      chk("R11 order after", d, 22 + k);
    end

    // R6 flush versus push, and flush of one side only
    rx_push(8'd9);
    @(negedge clk);
    fcr_we = 1'b1; fcr_wdata = 8'h03; rx_in_valid = 1'b1; rx_in_data = 8'd10;
    @(negedge clk);
    fcr_we = 1'b0; rx_in_valid = 1'b0;
    chk("R6 flush beats push", rx_level, 0);
    rx_push(8'd1); rx_push(8'd2); tx_push(8'd3); tx_push(8'd4);
    fcr(8'h05);
    chk("R6 tx flushed", tx_level, 0);
    chk("R6 rx kept", rx_level, 2);
    rx_push(8'd5);
    chk("R6 flush bit not kept", rx_level, 3);

    finish_run();
  end

endmodule